// File: doc/BRIEF.md
# Operand Width Class Monitor

This monitor sits beside an execute stage and watches one chosen instruction kind, such as a multiply or a divide. The instruction word is compared against a match value under a mask. For a selected instruction, each operand value is sorted into width and signedness classes: signed or unsigned, 8, 16 or 32 bits. The monitor then raises a flag for each operand whose value breaks its configured constraint.

Each operand (first source, second source, destination) has its own class set and its own polarity. A set can forbid the listed classes, or it can allow only the listed classes. A shared mode can instead apply the first source's set to all three operands. Sets are fixed at elaboration, and a set with a gap inside one signedness stops elaboration. Such a set cannot be enforced, because a small value fits every wider class of the same signedness as well as the narrow one.

Top module: `opdt_monitor`

## Requirements
- R1: A value is in class i8 (set bit 0) exactly when bits [31:7] are all equal, i.e. -128..127.
- R2: A value is in class u8 (set bit 1) exactly when bits [31:8] are zero, i.e. 0..255.
- R3: A value is in class i16 (set bit 2) exactly when bits [31:15] are all equal, and in class u16 (set bit 3) exactly when bits [31:16] are zero.
- R4: Classes i32 (set bit 4) and u32 (set bit 5) contain every 32-bit value.
- R5: In forbid polarity (0), an operand violates when its value is in any class of its set.
- R6: In allow-only polarity (1), an operand violates when its value is in none of the classes of its set.
- R7: Each operand uses its own set and polarity. When SHARED=1, all three operands use the first source's set and polarity, and the other two configurations have no effect.
- R8: The source flags reflect the operands sampled on a cycle with src_valid_i high, appear one clock later, and last one cycle.
- R9: The destination flag reflects rd_val_i sampled on a cycle with res_valid_i high, appears one clock later, and only if the most recent src_valid_i instruction matched.
- R10: An instruction with (instr_i & OPC_MASK) != OPC_MATCH never raises a source flag, whatever its operands.
- R11: During and immediately after reset, all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Instruction and source operands valid |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | First source operand value |
| rs2_val_i | input | 32 | Second source operand value |
| res_valid_i | input | 1 | Result value valid |
| rd_val_i | input | 32 | Result value |
| viol_rs1_o | output | 1 | First source violated its constraint |
| viol_rs2_o | output | 1 | Second source violated its constraint |
| viol_rd_o | output | 1 | Result violated its constraint |

## Verification
The bench builds two instances, both matching the multiply encoding (match 0x02000033, mask 0xFE00707F). u0 uses separate sets: allow {i8,i16} on the first source, forbid {u8,u16} on the second, and allow {i8,u8} on the result. Together these place each classification edge (-129, -32769, 255, 256, 65535, 65536) on both sides of a flag in both polarities. u1 is built in shared mode with allow {i8,i16,i32}, while its unused second-source and result sets would flag small or large values. This shows that the full-width classes accept everything and that the shared set overrides the others.

// File: rtl/opdt_pkg.sv
package opdt_pkg;
  localparam int DW   = 32;
  localparam int NW   = 2;          // narrow widths checked: 8, 16
  localparam int NCLS = 2 * NW + 2; // + i32, u32

  typedef logic [NCLS-1:0] cls_set_t;
  typedef enum logic {POL_FORBID = 1'b0, POL_ALLOW = 1'b1} pol_e;

  // bit 2*k = signed, 2*k+1 = unsigned, width 8<<k
  function automatic bit set_ok(cls_set_t s, pol_e p);
    bit ok = 1'b1;
    for (int g = 0; g < 2; g++) begin
      bit lo, mid, hi;
      lo  = s[g];
      mid = s[g+2];
      hi  = s[g+4];
      if (lo && !mid && hi) ok = 1'b0;
      if (p == POL_ALLOW && ((mid && !lo) || (hi && !mid))) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/opdt_classify.sv
module opdt_classify
  import opdt_pkg::*;
(
  input  logic [DW-1:0] val_i,
  output cls_set_t      fit_o
);
  for (genvar k = 0; k < NW; k++) begin : g_w
    localparam int W = 8 << k;
    logic [DW-W:0]   sx_bits;
    logic [DW-W-1:0] zx_bits;
    assign sx_bits        = val_i[DW-1:W-1];
    assign zx_bits        = val_i[DW-1:W];
    assign fit_o[2*k]     = (&sx_bits) | ~(|sx_bits);
    assign fit_o[2*k+1]   = ~(|zx_bits);
  end
  assign fit_o[NCLS-2] = 1'b1;
  assign fit_o[NCLS-1] = 1'b1;
endmodule

// File: rtl/opdt_judge.sv
module opdt_judge
  import opdt_pkg::*;
#(
  parameter cls_set_t SET = '0,
  parameter pol_e     POL = POL_FORBID
) (
  input  cls_set_t fit_i,
  output logic     viol_o
);
  if (!set_ok(SET, POL)) begin : g_bad_set
    $error("opdt_judge: class set has a gap for its polarity");
  end

  logic hit;
  assign hit    = |(fit_i & SET);
  assign viol_o = (POL == POL_ALLOW) ? ~hit : hit;
endmodule

// File: rtl/opdt_monitor.sv
module opdt_monitor
  import opdt_pkg::*;
#(
  parameter logic [DW-1:0] OPC_MATCH = 32'h0200_0033,
  parameter logic [DW-1:0] OPC_MASK  = 32'hFE00_707F,
  parameter bit            SHARED    = 1'b0,
  parameter cls_set_t      RS1_SET   = 6'b00_0101,
  parameter pol_e          RS1_POL   = POL_ALLOW,
  parameter cls_set_t      RS2_SET   = 6'b00_1010,
  parameter pol_e          RS2_POL   = POL_FORBID,
  parameter cls_set_t      RD_SET    = 6'b00_0011,
  parameter pol_e          RD_POL    = POL_ALLOW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          src_valid_i,
  input  logic [DW-1:0] instr_i,
  input  logic [DW-1:0] rs1_val_i,
  input  logic [DW-1:0] rs2_val_i,
  input  logic          res_valid_i,
  input  logic [DW-1:0] rd_val_i,
  output logic          viol_rs1_o,
  output logic          viol_rs2_o,
  output logic          viol_rd_o
);
  localparam int NOP = 3;

  logic [DW-1:0] op_val [NOP];
  cls_set_t      op_fit [NOP];
  logic [NOP-1:0] op_bad;
  logic [NOP-1:0] viol_q;
  logic           match, sel_q;

  assign op_val[0] = rs1_val_i;
  assign op_val[1] = rs2_val_i;
  assign op_val[2] = rd_val_i;
  assign match     = (instr_i & OPC_MASK) == OPC_MATCH;

  for (genvar k = 0; k < NOP; k++) begin : g_op
    localparam cls_set_t S = (k == 0 || SHARED) ? RS1_SET : (k == 1 ? RS2_SET : RD_SET);
    localparam pol_e     P = (k == 0 || SHARED) ? RS1_POL : (k == 1 ? RS2_POL : RD_POL);
    opdt_classify u_cls (.val_i(op_val[k]), .fit_o(op_fit[k]));
    opdt_judge #(.SET(S), .POL(P)) u_jdg (.fit_i(op_fit[k]), .viol_o(op_bad[k]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      viol_q[0] <= src_valid_i & match & op_bad[0];
      viol_q[1] <= src_valid_i & match & op_bad[1];
      viol_q[2] <= res_valid_i & sel_q & op_bad[2];
      if (src_valid_i) sel_q <= match;
    end
  end

  assign viol_rs1_o = viol_q[0];
  assign viol_rs2_o = viol_q[1];
  assign viol_rd_o  = viol_q[2];

  // narrow class membership implies the wider class of the same signedness
  assert_i8_in_i16_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_i |-> (!op_fit[0][0] || op_fit[0][2]));
  assert_u8_in_u16_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_i |-> (!op_fit[1][1] || op_fit[1][3]));
  assert_nomatch_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_i && !match) |=> (!viol_rs1_o && !viol_rs2_o));
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_valid_i |=> (!viol_rs1_o && !viol_rs2_o));
  assert_rd_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_i && sel_q) |=> !viol_rd_o);
endmodule

// File: tb/sim_opdt_monitor.sv
module sim_opdt_monitor;
  import opdt_pkg::*;

  localparam logic [31:0] MUL_W = 32'h0200_0033 | 32'h00B5_0500;
  localparam logic [31:0] ADD_W = 32'h0000_0033 | 32'h00B5_0500;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic src_valid = 1'b0, res_valid = 1'b0;
  logic [31:0] instr = '0, rs1 = '0, rs2 = '0, rd = '0;
  logic v1, v2, vd, w1, w2, wd;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  opdt_monitor u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_valid_i(src_valid), .instr_i(instr),
    .rs1_val_i(rs1), .rs2_val_i(rs2), .res_valid_i(res_valid), .rd_val_i(rd),
    .viol_rs1_o(v1), .viol_rs2_o(v2), .viol_rd_o(vd));

  opdt_monitor #(
    .SHARED(1'b1), .RS1_SET(6'b01_0101), .RS1_POL(POL_ALLOW),
    .RS2_SET(6'b00_1010), .RS2_POL(POL_FORBID),
    .RD_SET(6'b00_0011), .RD_POL(POL_ALLOW)
  ) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .src_valid_i(src_valid), .instr_i(instr),
    .rs1_val_i(rs1), .rs2_val_i(rs2), .res_valid_i(res_valid), .rd_val_i(rd),
    .viol_rs1_o(w1), .viol_rs2_o(w2), .viol_rd_o(wd));

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  // drive on negedge, sample after the following posedge
  task automatic src(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    src_valid = 1'b1; instr = i; rs1 = a; rs2 = b;
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic res(input logic [31:0] r);
    @(negedge clk);
    res_valid = 1'b1; rd = r;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(v1 | v2 | vd | w1 | w2 | wd, 1'b0, "R11 flags low in reset");
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(v1 | v2 | vd | w1 | w2 | wd, 1'b0, "R11 flags low after reset");
  endtask

  task automatic t_signed_edges; // u0 rs1 allow {i8,i16}
    src(MUL_W, 32'hFFFF_FF80, 32'h0001_0000); chk(v1, 1'b0, "R1 -128 is i8");
    src(MUL_W, 32'hFFFF_FF7F, 32'h0001_0000); chk(v1, 1'b0, "R3 -129 is i16");
    src(MUL_W, 32'hFFFF_7FFF, 32'h0001_0000); chk(v1, 1'b1, "R6 -32769 fits none");
    src(MUL_W, 32'h0000_7FFF, 32'h0001_0000); chk(v1, 1'b0, "R3 32767 is i16");
    src(MUL_W, 32'h0000_8000, 32'h0001_0000); chk(v1, 1'b1, "R6 32768 not i16");
  endtask

  task automatic t_unsigned_edges; // u0 rs2 forbid {u8,u16}
    src(MUL_W, 32'h0, 32'h0000_0000); chk(v2, 1'b1, "R2 0 is u8 forbidden");
    src(MUL_W, 32'h0, 32'h0000_00FF); chk(v2, 1'b1, "R5 255 forbidden");
    src(MUL_W, 32'h0, 32'h0000_FFFF); chk(v2, 1'b1, "R3 65535 is u16");
    src(MUL_W, 32'h0, 32'h0001_0000); chk(v2, 1'b0, "R5 65536 allowed");
    src(MUL_W, 32'h0, 32'hFFFF_FFFF); chk(v2, 1'b0, "R5 -1 not unsigned-narrow");
  endtask

  task automatic t_pulse;
    src(MUL_W, 32'h0000_8000, 32'h0);
    chk(v1 & v2, 1'b1, "R8 both flags one clock later");
    @(negedge clk);
    chk(v1 | v2, 1'b0, "R8 flags last one cycle");
  endtask

  task automatic t_nomatch;
    src(ADD_W, 32'h0000_8000, 32'h0);
    chk(v1 | v2, 1'b0, "R10 unmatched opcode quiet");
  endtask

  task automatic t_result; // u0 rd allow {i8,u8}
    src(MUL_W, 32'h0, 32'h0001_0000);
    res(32'h0000_00FF); chk(vd, 1'b0, "R2 rd 255 is u8");
    res(32'h0000_0100); chk(vd, 1'b1, "R9 rd 256 flagged");
    res(32'hFFFF_FF80); chk(vd, 1'b0, "R1 rd -128 is i8");
    res(32'hFFFF_FF7F); chk(vd, 1'b1, "R9 rd -129 flagged");
    @(negedge clk);
    chk(vd, 1'b0, "R9 rd flag one cycle");
    src(ADD_W, 32'h0, 32'h0);
    res(32'h0000_0100); chk(vd, 1'b0, "R9 rd of unmatched instr quiet");
  endtask

  task automatic t_shared; // u1 shared allow {i8,i16,i32}
    src(MUL_W, 32'h8000_0000, 32'h0000_0005);
    chk(w1, 1'b0, "R4 i32 covers 0x80000000");
    chk(w2, 1'b0, "R7 rs2 set overridden in shared mode");
    res(32'h7FFF_FFFF);
    chk(wd, 1'b0, "R7 rd set overridden in shared mode");
    chk(vd, 1'b1, "R7 u0 rd uses own set");
  endtask

  initial begin
    t_reset();
    t_signed_edges();
    t_unsigned_edges();
    t_pulse();
    t_nomatch();
    t_result();
    t_shared();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule